// File: doc/BRIEF.md
# Four-Channel Timer Input Capture Unit

This block timestamps external events. A 16-bit counter runs freely on the bus clock. Each of four channels watches one input pin, brings it into the clock domain through a two-stage synchronizer, and looks for the kind of transition that software selected for it. When that transition is seen, the current count is copied in one parallel transfer into the channel's 16-bit capture register, and the channel's sticky flag is set.

Software reaches the unit through a small single-cycle register port. It can write and read one 8-bit edge-mode register, and it can read and clear the flags. It reads each capture register as two read-only bytes. A read of a high byte holds off capture into that register at the end of the same bus cycle. An event that lands in that cycle is parked together with the count taken at detection, and it is written one cycle later. A high-byte read followed directly by a low-byte read therefore always returns the two halves of one sample. Channel 4 has an extra enable input and captures only while that input is high.

Top module: `icap_unit`

## Requirements
- R1: The counter holds 0 until the second clock edge after `rst_n` rises. From then on it adds 1 on every clock edge and wraps at 16 bits. A capture stores the count that is present in the clock cycle just before the third rising clock edge after the pin change is first sampled.
- R2: Each channel uses a 2-bit mode field. 00 ignores the pin, 01 captures on low-to-high changes only, 10 captures on high-to-low changes only, and 11 captures on both.
- R3: Address 0 is the readable and writable mode register. It is 0 after reset. Bits 7:6 hold the mode of channel 4, bits 5:4 channel 1, bits 3:2 channel 2 and bits 1:0 channel 3.
- R4: For channel k (1 to 4), the capture high byte reads at address 2k and the low byte at address 2k+1. Writes to these addresses change nothing.
- R5: Reset leaves the capture registers unchanged.
- R6: The new capture value and its flag first become visible after the third rising clock edge following the first sampling edge. Neither is visible before that edge.
- R7: While the high byte of a channel is being read, that channel's capture register does not change at the end of that cycle. A low-byte read in the next cycle returns the other half of the same value.
- R8: A capture that is held off by R7 is stored on the following clock edge. It keeps the count from the cycle of detection, and its flag is set at that same edge.
- R9: Channels are independent. Qualifying changes that two channels sample in the same cycle store equal counts.
- R10: Channel 4 captures only while `ch4_enable` is 1. Otherwise its pin changes leave its register and flag untouched.
- R11: Address 1 bits 0 to 3 are the sticky flags of channels 1 to 4. They are 0 after reset. Writing 1 to a bit clears that flag and writing 0 has no effect. A capture in the same cycle as a clear leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released internally in step with the clock |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when no read is active |
| cap_pin | input | 4 | Event pins, bit 0 = channel 1 up to bit 3 = channel 4 |
| ch4_enable | input | 1 | Allows channel 4 to capture |

## Verification
The checker assumes that bus inputs and pins change away from the rising clock edge. It also assumes that a channel's register moves only through a fresh detection or through the release of a parked one. On that basis it checks that a high-byte read freezes the register, that a parked capture is released when no block is active, that the off mode and the channel 4 gate prevent any transfer, and that every transfer sets its flag. The bench drives all inputs at the falling edge and holds each pin level for at least three clocks. Each access to the register port lasts exactly one cycle, so the single-cycle block and the one-cycle release line up with its checks.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  localparam int unsigned ADDR_MODE     = 0;
  localparam int unsigned ADDR_FLAGS    = 1;
  localparam int unsigned ADDR_CAP_BASE = 2;

  // Bit position of a channel's mode field inside the mode register.
  // Index 0 is channel 1; channel 4 sits in the top pair.
  function automatic int unsigned mode_lsb(input int unsigned idx);
    case (idx)
      0:       return 4;
      1:       return 2;
      2:       return 0;
      3:       return 6;
      default: return 2 * idx;
    endcase
  endfunction

endpackage

// File: rtl/icap_rst_sync.sv
module icap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/icap_counter.sv
module icap_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;

  always_comb cnt_d = cnt_q + WIDTH'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/icap_edge_sync.sv
module icap_edge_sync
  import icap_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  edge_mode_e mode,
  input  logic       enable,
  output logic       hit
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;
  logic            now_lvl, prev_lvl, went_up, went_down;

  always_comb sh_d = {sh_q[STAGES-1:0], pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign now_lvl   = sh_q[STAGES-1];
  assign prev_lvl  = sh_q[STAGES];
  assign went_up   = now_lvl & ~prev_lvl;
  assign went_down = ~now_lvl & prev_lvl;

  always_comb begin
    unique case (mode)
      EDGE_RISE: hit = enable & went_up;
      EDGE_FALL: hit = enable & went_down;
      EDGE_BOTH: hit = enable & (went_up | went_down);
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hit,
  input  logic             block,
  input  logic [WIDTH-1:0] count,
  input  logic             flag_clr,
  output logic [WIDTH-1:0] cap_o,
  output logic             took_o,
  output logic             pend_o,
  output logic             flag_o
);
  logic [WIDTH-1:0] cap_q, cap_d;
  logic [WIDTH-1:0] park_q, park_d;
  logic             park_en;
  logic             pend_q, pend_d;
  logic             flag_q, flag_d;
  logic             took;

  always_comb begin
    took    = 1'b0;
    cap_d   = cap_q;
    park_d  = park_q;
    park_en = 1'b0;
    pend_d  = pend_q;
    if (block) begin
      if (hit) begin
        park_en = 1'b1;
        park_d  = count;
        pend_d  = 1'b1;
      end
    end else if (hit) begin
      took   = 1'b1;
      cap_d  = count;
      pend_d = 1'b0;
    end else if (pend_q) begin
      took   = 1'b1;
      cap_d  = park_q;
      pend_d = 1'b0;
    end
    flag_d = took | (flag_q & ~flag_clr);
  end

  // Sample storage is deliberately left out of reset.
  always_ff @(posedge clk) begin
    if (took)    cap_q  <= cap_d;
    if (park_en) park_q <= park_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      flag_q <= flag_d;
    end
  end

  assign cap_o  = cap_q;
  assign took_o = took;
  assign pend_o = pend_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/icap_unit.sv
module icap_unit
  import icap_pkg::*;
#(
  parameter int unsigned NCH         = 4,
  parameter int unsigned CW          = 16,
  parameter int unsigned AW          = 4,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  input  logic [NCH-1:0] cap_pin,
  input  logic           ch4_enable
);
  localparam int unsigned MODE_W = 2 * NCH;

  logic                     rst_n_i;
  logic [CW-1:0]            count;
  logic [MODE_W-1:0]        mode_q, mode_d;
  logic                     rd_act, wr_act;
  logic [NCH-1:0]           hi_rd, hit, took, pend, flags, flag_clr;
  logic [NCH-1:0][CW-1:0]   cap;

  icap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_n_i)
  );

  icap_counter #(.WIDTH(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .count(count)
  );

  assign rd_act = bus_sel & ~bus_wr;
  assign wr_act = bus_sel & bus_wr;

  always_comb begin
    mode_d = mode_q;
    if (wr_act && bus_addr == AW'(ADDR_MODE)) mode_d = bus_wdata[MODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) mode_q <= '0;
    else          mode_q <= mode_d;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    localparam int unsigned LSB = mode_lsb(k);
    localparam logic [AW-1:0] HI_ADDR = AW'(ADDR_CAP_BASE + 2 * k);
    logic       en_k;
    edge_mode_e mode_k;

    assign mode_k      = edge_mode_e'(mode_q[LSB +: 2]);
    assign hi_rd[k]    = rd_act && (bus_addr == HI_ADDR);
    assign flag_clr[k] = wr_act && (bus_addr == AW'(ADDR_FLAGS)) && bus_wdata[k];

    if (k == NCH - 1) begin : g_gated
      assign en_k = ch4_enable;
    end else begin : g_free
      assign en_k = 1'b1;
    end

    icap_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst_n(rst_n_i), .pin(cap_pin[k]),
      .mode(mode_k), .enable(en_k), .hit(hit[k])
    );

    icap_channel #(.WIDTH(CW)) u_chan (
      .clk(clk), .rst_n(rst_n_i), .hit(hit[k]), .block(hi_rd[k]),
      .count(count), .flag_clr(flag_clr[k]),
      .cap_o(cap[k]), .took_o(took[k]), .pend_o(pend[k]), .flag_o(flags[k])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (rd_act) begin
      if (bus_addr == AW'(ADDR_MODE))  bus_rdata = DW'(mode_q);
      if (bus_addr == AW'(ADDR_FLAGS)) bus_rdata = DW'(flags);
      for (int k = 0; k < NCH; k++) begin
        if (bus_addr == AW'(ADDR_CAP_BASE + 2 * k))     bus_rdata = cap[k][CW-1 -: DW];
        if (bus_addr == AW'(ADDR_CAP_BASE + 2 * k + 1)) bus_rdata = cap[k][DW-1:0];
      end
    end
  end
endmodule

// File: rtl/icap_unit_chk.sv
module icap_unit_chk
  import icap_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned CW     = 16,
  parameter int unsigned MODE_W = 8
) (
  input logic                   clk,
  input logic                   rst_n_i,
  input logic [NCH-1:0]         hi_rd,
  input logic [NCH-1:0]         took,
  input logic [NCH-1:0]         pend,
  input logic [NCH-1:0]         flags,
  input logic [NCH-1:0][CW-1:0] cap,
  input logic [MODE_W-1:0]      mode_q,
  input logic                   ch4_enable
);
  for (genvar k = 0; k < NCH; k++) begin : g_chk
    localparam int unsigned LSB = mode_lsb(k);

    // R7: a high-byte read freezes the register across that edge
    assert_hiread_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
      hi_rd[k] |=> $stable(cap[k]));

    // R8: a parked capture is released on the first unblocked edge
    assert_parked_release_R8: assert property (@(posedge clk) disable iff (!rst_n_i)
      (pend[k] && !hi_rd[k]) |=> (flags[k] && !pend[k]));

    // R11: every transfer leaves the flag set, even against a clear
    assert_flag_on_take_R11: assert property (@(posedge clk) disable iff (!rst_n_i)
      took[k] |=> flags[k]);

    // R2: off mode with nothing parked never changes the register
    assert_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n_i)
      (mode_q[LSB +: 2] == 2'b00 && !pend[k]) |=> $stable(cap[k]));
  end

  // R10: channel 4 makes no fresh transfer while its enable is low
  assert_ch4_gate_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!ch4_enable && !pend[NCH-1]) |-> !took[NCH-1]);
endmodule

bind icap_unit icap_unit_chk #(.NCH(NCH), .CW(CW), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n_i(rst_n_i), .hi_rd(hi_rd), .took(took), .pend(pend),
  .flags(flags), .cap(cap), .mode_q(mode_q), .ch4_enable(ch4_enable)
);

// File: tb/icap_unit_test.sv
`timescale 1ns/1ps
module icap_unit_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_sel, bus_wr;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [3:0] cap_pin;
  logic       ch4_enable;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  icap_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .ch4_enable(ch4_enable)
  );

  // Counter model from R1: still for two edges after release, then +1 per edge
  logic        m1, m2;
  logic [15:0] bc;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1 <= 1'b0; m2 <= 1'b0; bc <= '0;
    end else begin
      m1 <= 1'b1; m2 <= m1;
      if (m2) bc <= bc + 16'd1;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 begin bus_sel = 1'b0; bus_wr = 1'b0; end
  endtask

  // ch is 1..4; high byte at 2*ch, low byte at 2*ch+1
  task automatic rd16(input int ch, output logic [15:0] v);
    logic [7:0] h, l;
    rd(4'(2 * ch), h);
    rd(4'(2 * ch + 1), l);
    v = {h, l};
  endtask

  // Change pin idx and return the count that R1 says will be captured
  task automatic pin_event(input int idx, input logic lvl, output logic [15:0] exp);
    @(negedge clk);
    cap_pin[idx] = lvl;
    @(posedge clk);
    @(posedge clk);
    #1 exp = bc;
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(3);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic t_reset_state();
    logic [7:0] d;
    rd(4'd0, d); chk("R3", "mode reg after reset", 16'(d), 16'h00);
    rd(4'd1, d); chk("R11", "flags after reset", 16'(d), 16'h00);
  endtask

  task automatic t_mode_rw();
    logic [7:0] d;
    wr(4'd0, 8'h5A);
    rd(4'd0, d); chk("R3", "mode readback", 16'(d), 16'h5A);
    wr(4'd0, 8'h00);
  endtask

  task automatic t_rise();
    logic [15:0] exp, v, prev;
    logic [7:0] d;
    wr(4'd0, 8'h10); // channel 1 -> 01 rising
    wr(4'd1, 8'h0F);
    @(negedge clk);
    cap_pin[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 exp = bc;
    rd(4'd1, d); chk("R6", "flag before third edge", 16'(d), 16'h00);
    rd(4'd1, d); chk("R6", "flag after third edge", 16'(d), 16'h01);
    rd16(1, v);  chk("R1", "rising capture ch1", v, exp);
    prev = v;
    wr(4'd1, 8'h01);
    @(negedge clk); cap_pin[0] = 1'b0;
    idle(6);
    rd(4'd1, d); chk("R2", "falling ignored in rise mode flag", 16'(d), 16'h00);
    rd16(1, v);  chk("R2", "falling ignored in rise mode value", v, prev);
  endtask

  task automatic t_fall();
    logic [15:0] exp, v, prev;
    logic [7:0] d;
    wr(4'd0, 8'h08); // channel 2 -> 10 falling
    rd16(2, prev);
    wr(4'd1, 8'h0F);
    @(negedge clk); cap_pin[1] = 1'b1;
    idle(6);
    rd(4'd1, d); chk("R2", "rising ignored in fall mode", 16'(d), 16'h00);
    rd16(2, v);  chk("R2", "ch2 unchanged on rise", v, prev);
    pin_event(1, 1'b0, exp);
    rd16(2, v);  chk("R2", "falling capture ch2", v, exp);
    rd(4'd1, d); chk("R11", "ch2 flag bit1", 16'(d), 16'h02);
  endtask

  task automatic t_both();
    logic [15:0] e1, e2, v;
    wr(4'd0, 8'h03); // channel 3 -> 11 both
    pin_event(2, 1'b1, e1);
    rd16(3, v); chk("R2", "both mode rising ch3", v, e1);
    pin_event(2, 1'b0, e2);
    rd16(3, v); chk("R2", "both mode falling ch3", v, e2);
  endtask

  task automatic t_disabled();
    logic [15:0] prev, v;
    logic [7:0] d;
    wr(4'd0, 8'h00);
    wr(4'd1, 8'h0F);
    rd16(1, prev);
    @(negedge clk); cap_pin[0] = 1'b1;
    idle(5);
    @(negedge clk); cap_pin[0] = 1'b0;
    idle(5);
    rd(4'd1, d); chk("R2", "disabled flags", 16'(d), 16'h00);
    rd16(1, v);  chk("R2", "disabled ch1 unchanged", v, prev);
  endtask

  task automatic t_same_count();
    logic [15:0] exp, a, b;
    wr(4'd0, 8'h14); // channels 1 and 2 rising
    @(negedge clk); cap_pin[0] = 1'b1; cap_pin[1] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 exp = bc;
    idle(2);
    rd16(1, a); chk("R9", "ch1 simultaneous", a, exp);
    rd16(2, b); chk("R9", "ch2 simultaneous", b, exp);
  endtask

  task automatic t_interlock();
    logic [15:0] old, exp, v;
    logic [7:0] d;
    wr(4'd0, 8'h30); // channel 1 -> both
    rd16(1, old);
    wr(4'd1, 8'h0F);
    @(negedge clk); cap_pin[0] = 1'b0;
    @(posedge clk);
    @(posedge clk);
    #1 exp = bc;
    rd(4'd2, d); chk("R7", "high byte during block", 16'(d), 16'(old[15:8]));
    rd(4'd3, d); chk("R7", "low byte stays coherent", 16'(d), 16'(old[7:0]));
    rd(4'd1, d); chk("R8", "flag after deferred take", 16'(d), 16'h01);
    rd16(1, v);  chk("R8", "deferred value is detection count", v, exp);
  endtask

  task automatic t_ch4_gate();
    logic [15:0] prev, exp, v;
    logic [7:0] d;
    wr(4'd0, 8'hC0); // channel 4 -> both
    wr(4'd1, 8'h0F);
    ch4_enable = 1'b0;
    rd16(4, prev);
    @(negedge clk); cap_pin[3] = 1'b1;
    idle(6);
    rd(4'd1, d); chk("R10", "ch4 flag while gated", 16'(d), 16'h00);
    rd16(4, v);  chk("R10", "ch4 value while gated", v, prev);
    @(negedge clk); ch4_enable = 1'b1;
    pin_event(3, 1'b0, exp);
    rd16(4, v);  chk("R10", "ch4 capture when enabled", v, exp);
    rd(4'd1, d); chk("R10", "ch4 flag bit3", 16'(d), 16'h08);
  endtask

  task automatic t_flags();
    logic [7:0] d;
    wr(4'd0, 8'h03); // channel 3 both
    wr(4'd1, 8'h0F);
    @(negedge clk); cap_pin[2] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1;
    wr(4'd1, 8'h04); // clear lands on the capture edge
    rd(4'd1, d); chk("R11", "set beats clear", 16'(d), 16'h04);
    wr(4'd1, 8'h0B);
    rd(4'd1, d); chk("R11", "write of 0 keeps flag", 16'(d), 16'h04);
    wr(4'd1, 8'h04);
    rd(4'd1, d); chk("R11", "write of 1 clears", 16'(d), 16'h00);
  endtask

  task automatic t_readonly();
    logic [15:0] prev, v;
    rd16(3, prev);
    wr(4'd6, ~prev[15:8]);
    wr(4'd7, ~prev[7:0]);
    rd16(3, v); chk("R4", "capture bytes read-only", v, prev);
  endtask

  task automatic t_reset_keep();
    logic [15:0] prev, v, exp;
    logic [7:0] d;
    wr(4'd0, 8'hFF);
    rd16(2, prev);
    do_reset();
    rd16(2, v);  chk("R5", "ch2 survives reset", v, prev);
    rd(4'd0, d); chk("R3", "mode cleared by reset", 16'(d), 16'h00);
    rd(4'd1, d); chk("R11", "flags cleared by reset", 16'(d), 16'h00);
    wr(4'd0, 8'h08); // channel 2 falling; pin1 is high
    pin_event(1, 1'b0, exp);
    rd16(2, v);  chk("R1", "count restarts after reset", v, exp);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; cap_pin = '0; ch4_enable = 1'b0;
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    idle(3);
    t_reset_state();
    t_mode_rw();
    t_rise();
    t_fall();
    t_both();
    t_disabled();
    t_same_count();
    t_interlock();
    t_ch4_gate();
    t_flags();
    t_readonly();
    t_reset_keep();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule